// File: doc/BRIEF.md
# Multi-Attribute Block Pattern Encoder

This block turns a stream of data symbols into per-block drawing descriptors for a screen-to-camera link. Every symbol is split into four visual attributes: a transparency flag, a block size code, a shape code and a colour code. A downstream renderer uses these to paint one block of the frame. Three symbol widths are supported: 6, 7 and 8 bits, for 2, 4 or 8 colours. The fewer the colours, the lower the bit positions that feed the transparency, size and shape fields.

Symbols are accepted through a valid/ready handshake. Each accepted symbol is bound to the next grid position, walked left to right across a row and then down to the next row. The grid is either a configured partial area or a fixed full-screen area. After the last block of a grid, a completion pulse is raised. Intake then pauses for a configured number of cycles so that the finished frame can be shown before the next one starts at the top-left position.

Top module: `blkpat_encoder`

## Requirements
- R1: After reset, in_ready is 1, out_valid and frame_done are 0, and the first accepted symbol is placed at x=0, y=0.
- R2: With cfg_mode=2 (8 bits per symbol), sym bit 7 is the transparency flag, bits 6:5 are the size code, bits 4:3 are the shape code and bits 2:0 are the colour code.
- R3: With cfg_mode=1 (7 bits), sym bit 6 is transparency, bits 5:4 are size, bits 3:2 are shape and bits 1:0 are colour (colour 0..3). Bit 7 has no effect.
- R4: With cfg_mode=0 (6 bits), sym bit 5 is transparency, bits 4:3 are size, bits 2:1 are shape and bit 0 is colour (colour 0..1). Bits 7:6 have no effect. cfg_mode=3 behaves as the 8-bit mode.
- R5: out_opaque equals the transparency flag. out_alpha_pct is 0 when the flag is 1 and 50 when the flag is 0.
- R6: out_size_px is 128, 96, 64 or 32 for size codes 0, 1, 2 or 3.
- R7: out_shape codes 0..3 are square, circle, hexagon and star. out_colour codes 0..7 are black, red, green, blue, yellow, magenta, cyan and white. The 2- and 4-colour modes use the first 2 or 4 entries.
- R8: Positions advance x by one per symbol. After x reaches the grid width minus one, x returns to 0 and y increments.
- R9: frame_done is high for exactly the cycle that carries the descriptor of the last grid block. The symbol after it is placed at x=0, y=0.
- R10: After the last block is accepted, in_ready stays low for cfg_repeat cycles. A symbol offered in that time produces no descriptor.
- R11: With cfg_full=1 the grid is FULL_H by FULL_V (60 by 32 by default), and cfg_h_cnt and cfg_v_cnt are ignored.
- R12: In partial mode a zero count is treated as 1, and a count above MAX_H or MAX_V is limited to that maximum.
- R13: A descriptor appears with out_valid high in the cycle after its handshake. out_valid is high for one cycle per accepted symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Bits-per-symbol select: 0=6, 1=7, 2 or 3=8 |
| cfg_full | input | 1 | 1 selects the fixed full-screen grid |
| cfg_h_cnt | input | clog2(MAX_H+1) | Partial grid width in blocks |
| cfg_v_cnt | input | clog2(MAX_V+1) | Partial grid height in blocks |
| cfg_repeat | input | REP_W | Hold cycles after a completed grid |
| in_valid | input | 1 | Symbol offered |
| in_ready | output | 1 | Symbol can be accepted |
| in_sym | input | 8 | Symbol, right-aligned, most significant field first |
| out_valid | output | 1 | Descriptor valid |
| out_x | output | clog2(MAX_H) | Block column |
| out_y | output | clog2(MAX_V) | Block row |
| out_opaque | output | 1 | Transparency flag |
| out_alpha_pct | output | 7 | Transparency percentage |
| out_size_code | output | 2 | Size code |
| out_size_px | output | 8 | Block edge in pixels |
| out_shape | output | 2 | Shape code |
| out_colour | output | 3 | Colour code |
| frame_done | output | 1 | Last block of the grid |

## Verification
Three events share one cycle: the descriptor of the final grid block, the frame_done pulse, and the entry into the hold window. The bench makes this happen in small partial grids, in a clamped one-block grid (where every symbol completes a frame) and in the full-screen grid. It checks that frame_done appears only alongside that last descriptor. It then keeps a symbol offered while the hold runs. It counts exactly cfg_repeat cycles of low in_ready with no descriptor, and checks that the next symbol lands at the origin.

// File: rtl/blkpat_pkg.sv
package blkpat_pkg;

    typedef enum logic [1:0] {
        BPS6    = 2'd0,
        BPS7    = 2'd1,
        BPS8    = 2'd2,
        BPS_RSV = 2'd3
    } bps_mode_e;

    typedef enum logic [1:0] {
        SHP_SQUARE  = 2'd0,
        SHP_CIRCLE  = 2'd1,
        SHP_HEXAGON = 2'd2,
        SHP_STAR    = 2'd3
    } shape_e;

    typedef enum logic [2:0] {
        COL_BLACK   = 3'd0,
        COL_RED     = 3'd1,
        COL_GREEN   = 3'd2,
        COL_BLUE    = 3'd3,
        COL_YELLOW  = 3'd4,
        COL_MAGENTA = 3'd5,
        COL_CYAN    = 3'd6,
        COL_WHITE   = 3'd7
    } colour_e;

    typedef struct packed {
        logic       opaque;
        logic [1:0] size_code;
        shape_e     shape;
        colour_e    colour;
    } attr_t;

    // Edge length shrinks by 32 pixels per size step, starting at 128.
    function automatic logic [7:0] size_to_px(input logic [1:0] code);
        return 8'd128 - {1'b0, code, 5'b00000};
    endfunction

    function automatic logic [6:0] flag_to_alpha(input logic opaque);
        return opaque ? 7'd0 : 7'd50;
    endfunction

endpackage

// File: rtl/blkpat_field_map.sv
module blkpat_field_map
    import blkpat_pkg::*;
(
    input  bps_mode_e  mode,
    input  logic [7:0] sym,
    output attr_t      attr
);

    always_comb begin
        case (mode)
            BPS6: begin
                attr.opaque    = sym[5];
                attr.size_code = sym[4:3];
                attr.shape     = shape_e'(sym[2:1]);
                attr.colour    = colour_e'({2'b00, sym[0]});
            end
            BPS7: begin
                attr.opaque    = sym[6];
                attr.size_code = sym[5:4];
                attr.shape     = shape_e'(sym[3:2]);
                attr.colour    = colour_e'({1'b0, sym[1:0]});
            end
            default: begin
                attr.opaque    = sym[7];
                attr.size_code = sym[6:5];
                attr.shape     = shape_e'(sym[4:3]);
                attr.colour    = colour_e'(sym[2:0]);
            end
        endcase
    end

endmodule

// File: rtl/blkpat_grid_walker.sv
module blkpat_grid_walker #(
    parameter int MAX_H  = 64,
    parameter int MAX_V  = 64,
    parameter int FULL_H = 60,
    parameter int FULL_V = 32,
    parameter int REP_W  = 8,
    localparam int XW    = $clog2(MAX_H),
    localparam int YW    = $clog2(MAX_V),
    localparam int HCW   = $clog2(MAX_H + 1),
    localparam int VCW   = $clog2(MAX_V + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             full,
    input  logic [HCW-1:0]   h_cnt,
    input  logic [VCW-1:0]   v_cnt,
    input  logic [REP_W-1:0] repeat_cnt,
    input  logic             fire,
    output logic             ready,
    output logic [XW-1:0]    x,
    output logic [YW-1:0]    y,
    output logic             last
);

    logic [HCW-1:0]   eff_h;
    logic [VCW-1:0]   eff_v;
    logic [REP_W-1:0] hold_q;
    logic             last_col;
    logic             last_row;

    always_comb begin
        if (full) begin
            eff_h = HCW'(FULL_H);
            eff_v = VCW'(FULL_V);
        end else begin
            if (h_cnt == '0)                 eff_h = HCW'(1);
            else if (h_cnt > HCW'(MAX_H))    eff_h = HCW'(MAX_H);
            else                             eff_h = h_cnt;
            if (v_cnt == '0)                 eff_v = VCW'(1);
            else if (v_cnt > VCW'(MAX_V))    eff_v = VCW'(MAX_V);
            else                             eff_v = v_cnt;
        end
    end

    // >= keeps the walk bounded if the grid shrinks mid-frame.
    assign last_col = HCW'(x) >= (eff_h - HCW'(1));
    assign last_row = VCW'(y) >= (eff_v - VCW'(1));
    assign last     = last_col && last_row;
    assign ready    = (hold_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            x      <= '0;
            y      <= '0;
            hold_q <= '0;
        end else if (fire) begin
            if (last_col) begin
                x <= '0;
                if (last_row) begin
                    y      <= '0;
                    hold_q <= repeat_cnt;
                end else begin
                    y <= y + 1'b1;
                end
            end else begin
                x <= x + 1'b1;
            end
        end else if (hold_q != '0) begin
            hold_q <= hold_q - REP_W'(1);
        end
    end

    a_r8_step_right: assert property (@(posedge clk) disable iff (rst)
        (fire && !last_col) |=> (x == XW'($past(x) + 1'b1)) && (y == $past(y)));

    a_r8_next_row: assert property (@(posedge clk) disable iff (rst)
        (fire && last_col && !last_row) |=> (x == '0) && (y == YW'($past(y) + 1'b1)));

    a_r9_wrap_origin: assert property (@(posedge clk) disable iff (rst)
        (fire && last) |=> (x == '0) && (y == '0));

    a_r10_hold_blocks: assert property (@(posedge clk) disable iff (rst)
        (fire && last && (repeat_cnt != '0)) |=> !ready);

    a_r10_hold_frozen: assert property (@(posedge clk) disable iff (rst)
        !ready |=> $stable(x) && $stable(y));

endmodule

// File: rtl/blkpat_encoder.sv
module blkpat_encoder
    import blkpat_pkg::*;
#(
    parameter int MAX_H  = 64,
    parameter int MAX_V  = 64,
    parameter int FULL_H = 60,
    parameter int FULL_V = 32,
    parameter int REP_W  = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [1:0]                   cfg_mode,
    input  logic                         cfg_full,
    input  logic [$clog2(MAX_H+1)-1:0]   cfg_h_cnt,
    input  logic [$clog2(MAX_V+1)-1:0]   cfg_v_cnt,
    input  logic [REP_W-1:0]             cfg_repeat,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [7:0]                   in_sym,
    output logic                         out_valid,
    output logic [$clog2(MAX_H)-1:0]     out_x,
    output logic [$clog2(MAX_V)-1:0]     out_y,
    output logic                         out_opaque,
    output logic [6:0]                   out_alpha_pct,
    output logic [1:0]                   out_size_code,
    output logic [7:0]                   out_size_px,
    output logic [1:0]                   out_shape,
    output logic [2:0]                   out_colour,
    output logic                         frame_done
);

    localparam int XW = $clog2(MAX_H);
    localparam int YW = $clog2(MAX_V);

    attr_t         attr;
    logic          fire;
    logic          at_last;
    logic [XW-1:0] pos_x;
    logic [YW-1:0] pos_y;

    assign fire = in_valid && in_ready;

    blkpat_field_map u_map (
        .mode (bps_mode_e'(cfg_mode)),
        .sym  (in_sym),
        .attr (attr)
    );

    blkpat_grid_walker #(
        .MAX_H  (MAX_H),
        .MAX_V  (MAX_V),
        .FULL_H (FULL_H),
        .FULL_V (FULL_V),
        .REP_W  (REP_W)
    ) u_walk (
        .clk        (clk),
        .rst        (rst),
        .full       (cfg_full),
        .h_cnt      (cfg_h_cnt),
        .v_cnt      (cfg_v_cnt),
        .repeat_cnt (cfg_repeat),
        .fire       (fire),
        .ready      (in_ready),
        .x          (pos_x),
        .y          (pos_y),
        .last       (at_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid     <= 1'b0;
            frame_done    <= 1'b0;
            out_x         <= '0;
            out_y         <= '0;
            out_opaque    <= 1'b0;
            out_alpha_pct <= '0;
            out_size_code <= '0;
            out_size_px   <= '0;
            out_shape     <= '0;
            out_colour    <= '0;
        end else begin
            out_valid  <= fire;
            frame_done <= fire && at_last;
            if (fire) begin
                out_x         <= pos_x;
                out_y         <= pos_y;
                out_opaque    <= attr.opaque;
                out_alpha_pct <= flag_to_alpha(attr.opaque);
                out_size_code <= attr.size_code;
                out_size_px   <= size_to_px(attr.size_code);
                out_shape     <= attr.shape;
                out_colour    <= attr.colour;
            end
        end
    end

    a_r13_follows_fire: assert property (@(posedge clk) disable iff (rst)
        fire |=> out_valid);

    a_r13_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !out_valid);

    a_r9_done_with_desc: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> out_valid);

    a_r6_size_matches: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_size_px == 8'd128 - 8'(out_size_code) * 8'd32));

endmodule

// File: tb/blkpat_encoder_bench.sv
module blkpat_encoder_bench;

    localparam int MAX_H = 64;
    localparam int MAX_V = 64;
    localparam int REP_W = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_mode = 2'd2;
    logic        cfg_full = 1'b0;
    logic [6:0]  cfg_h_cnt = 7'd4;
    logic [6:0]  cfg_v_cnt = 7'd3;
    logic [7:0]  cfg_repeat = 8'd0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_sym = 8'h00;
    logic        out_valid;
    logic [5:0]  out_x;
    logic [5:0]  out_y;
    logic        out_opaque;
    logic [6:0]  out_alpha_pct;
    logic [1:0]  out_size_code;
    logic [7:0]  out_size_px;
    logic [1:0]  out_shape;
    logic [2:0]  out_colour;
    logic        frame_done;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    blkpat_encoder #(.MAX_H(MAX_H), .MAX_V(MAX_V), .REP_W(REP_W)) u_blkpat_encoder (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_full(cfg_full),
        .cfg_h_cnt(cfg_h_cnt), .cfg_v_cnt(cfg_v_cnt), .cfg_repeat(cfg_repeat),
        .in_valid(in_valid), .in_ready(in_ready), .in_sym(in_sym),
        .out_valid(out_valid), .out_x(out_x), .out_y(out_y),
        .out_opaque(out_opaque), .out_alpha_pct(out_alpha_pct),
        .out_size_code(out_size_code), .out_size_px(out_size_px),
        .out_shape(out_shape), .out_colour(out_colour), .frame_done(frame_done)
    );

    // {mode, symbol, opaque, size, shape, colour}
    localparam logic [17:0] VEC [12] = '{
        {2'd2, 8'hB3, 1'b1, 2'b01, 2'b10, 3'b011},
        {2'd2, 8'h7F, 1'b0, 2'b11, 2'b11, 3'b111},
        {2'd2, 8'h00, 1'b0, 2'b00, 2'b00, 3'b000},
        {2'd1, 8'h66, 1'b1, 2'b10, 2'b01, 3'b010},
        {2'd1, 8'hFF, 1'b1, 2'b11, 2'b11, 3'b011},
        {2'd1, 8'h80, 1'b0, 2'b00, 2'b00, 3'b000},
        {2'd0, 8'h19, 1'b0, 2'b11, 2'b00, 3'b001},
        {2'd0, 8'hC0, 1'b0, 2'b00, 2'b00, 3'b000},
        {2'd0, 8'h2A, 1'b1, 2'b01, 2'b01, 3'b000},
        {2'd3, 8'hE5, 1'b1, 2'b11, 2'b00, 3'b101},
        {2'd2, 8'h4C, 1'b0, 2'b10, 2'b01, 3'b100},
        {2'd0, 8'h3F, 1'b1, 2'b11, 2'b11, 3'b001}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    // Returns at the falling edge after the handshake, where the descriptor is visible.
    task automatic send(input logic [7:0] s);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_sym   = s;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 ready", int'(in_ready), 1);
        chk("R1 valid", int'(out_valid), 0);
        chk("R1 done", int'(frame_done), 0);

        // Table walk on a 4x3 partial grid: R2..R8, R9, R13
        cfg_h_cnt = 7'd4; cfg_v_cnt = 7'd3; cfg_repeat = 8'd0; cfg_full = 1'b0;
        for (int i = 0; i < 12; i++) begin
            cfg_mode = VEC[i][17:16];
            send(VEC[i][15:8]);
            chk("R13 valid", int'(out_valid), 1);
            chk("R2/R3/R4 opaque", int'(out_opaque), int'(VEC[i][7]));
            chk("R2/R3/R4 size", int'(out_size_code), int'(VEC[i][6:5]));
            chk("R7 shape", int'(out_shape), int'(VEC[i][4:3]));
            chk("R7 colour", int'(out_colour), int'(VEC[i][2:0]));
            chk("R5 alpha", int'(out_alpha_pct), VEC[i][7] ? 0 : 50);
            chk("R6 px", int'(out_size_px), 128 - 32 * int'(VEC[i][6:5]));
            chk("R8 x", int'(out_x), i % 4);
            chk("R8 y", int'(out_y), i / 4);
            chk("R9 done", int'(frame_done), (i == 11) ? 1 : 0);
            if (i == 0) chk("R1 origin", int'(out_x) + int'(out_y), 0);
            @(negedge clk);
            chk("R13 single", int'(out_valid), 0);
        end

        // R10 hold window on a 2x2 grid
        do_reset();
        cfg_mode = 2'd2; cfg_h_cnt = 7'd2; cfg_v_cnt = 7'd2; cfg_repeat = 8'd3;
        for (int i = 0; i < 4; i++) send(8'h11);
        chk("R9 done last", int'(frame_done), 1);
        chk("R10 ready low", int'(in_ready), 0);
        in_valid = 1'b1;
        in_sym   = 8'hFF;
        begin
            int lows = 0;
            while (!in_ready && lows < 10) begin
                lows++;
                @(negedge clk);
                chk("R10 ignored", int'(out_valid), 0);
                chk("R9 one pulse", int'(frame_done), 0);
            end
            in_valid = 1'b0;
            chk("R10 hold len", lows, 3);
        end
        send(8'h00);
        chk("R9 restart x", int'(out_x), 0);
        chk("R9 restart y", int'(out_y), 0);
        chk("R10 restart colour", int'(out_colour), 0);

        // R12 zero counts act as one
        do_reset();
        cfg_repeat = 8'd0; cfg_h_cnt = 7'd0; cfg_v_cnt = 7'd0;
        for (int i = 0; i < 2; i++) begin
            send(8'h05);
            chk("R12 zero x", int'(out_x), 0);
            chk("R12 zero done", int'(frame_done), 1);
        end

        // R12 oversize width limited to MAX_H
        do_reset();
        cfg_h_cnt = 7'd100; cfg_v_cnt = 7'd1;
        begin
            int dones = 0;
            for (int i = 0; i < MAX_H; i++) begin
                send(8'h01);
                if (frame_done) dones++;
                if (i == MAX_H - 1) begin
                    chk("R12 clamp x", int'(out_x), MAX_H - 1);
                    chk("R12 clamp done", int'(frame_done), 1);
                end
            end
            chk("R12 clamp pulses", dones, 1);
        end

        // R11 full grid ignores the partial counts
        do_reset();
        cfg_full = 1'b1; cfg_h_cnt = 7'd3; cfg_v_cnt = 7'd3;
        begin
            int dones = 0;
            for (int i = 0; i < 60 * 32; i++) begin
                send(8'h02);
                if (frame_done) dones++;
                if (i == 59) begin
                    chk("R11 x edge", int'(out_x), 59);
                    chk("R11 y edge", int'(out_y), 0);
                end
                if (i == 60) begin
                    chk("R11 x wrap", int'(out_x), 0);
                    chk("R11 y step", int'(out_y), 1);
                end
                if (i == 60 * 32 - 1) begin
                    chk("R11 last y", int'(out_y), 31);
                    chk("R11 last done", int'(frame_done), 1);
                end
            end
            chk("R11 one done", dones, 1);
        end

        summary();
    end

endmodule